// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the sequencing controller for a processor datapath that spreads each instruction over several clock cycles. Every cycle it drives all of the datapath's write strobes and multiplexer selects. A 4-bit state register holds the current step of the instruction. The strobes and selects depend only on that register, so the controller is a Moore machine.

The one data input is the 6-bit major opcode, taken from the datapath's instruction register. The controller reads it only when it leaves the decode step and when it leaves the address step. Each instruction class follows its own chain of steps and then returns to the fetch step. A jump or a branch takes three cycles, a register-to-register operation or a store takes four, and a load takes five. If decode meets an opcode it does not recognise, the controller goes straight back to fetch. It then raises an illegal-instruction flag for the single fetch cycle that follows.

There are no streaming interfaces. All pins are plain level signals that are valid for the whole cycle.

Top module: `mc_seq_ctrl`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) puts the state at 0000 (fetch) and clears illegal_op after that edge.
- R2: In state 0000 the outputs are pc_load=1, mem_rd=1, ir_load=1, addr_from_alu=0, alu_a_sel=0, alu_b_sel=01, alu_ctl=00, pc_src=00. The next state is always 0001.
- R3: In state 0001 the outputs are alu_a_sel=0, alu_b_sel=11, alu_ctl=00, with no write strobe. The opcode then selects the next state: 000000 goes to 0110, 000010 goes to 1001, 000100 goes to 1000, and 100011 or 101011 goes to 0010.
- R4: In state 0010 the outputs are alu_a_sel=1, alu_b_sel=10, alu_ctl=00. If the opcode is 100011 the next state is 0011; any other opcode goes to 0101.
- R5: State 0011 drives mem_rd=1 and addr_from_alu=1 and moves to 0100. State 0100 drives rf_wr=1, rf_dst_rd=0, wb_from_mem=1 and moves to 0000.
- R6: State 0101 drives mem_wr=1 and addr_from_alu=1 and moves to 0000.
- R7: State 0110 drives alu_a_sel=1, alu_b_sel=00, alu_ctl=10 and moves to 0111. State 0111 drives rf_wr=1, rf_dst_rd=1, wb_from_mem=0 and moves to 0000.
- R8: State 1000 drives pc_load_if_zero=1, alu_a_sel=1, alu_b_sel=00, alu_ctl=01, pc_src=01 and moves to 0000.
- R9: State 1001 drives pc_load=1 and pc_src=10 and moves to 0000.
- R10: pc_load, pc_load_if_zero, ir_load, mem_wr and rf_wr are 0 in every state that R2 to R9 do not list them for. Every select or strobe not listed for a state is 0.
- R11: Any opcode in state 0001 other than those listed in R3 sends the state to 0000. illegal_op is then 1 for exactly that one fetch cycle and 0 at all other times.
- R12: Counted from fetch to the next fetch, a jump or branch takes 3 cycles, a register operation or store takes 4, and a load takes 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 6 | Major opcode from the instruction register |
| state_o | output | 4 | Current step encoding |
| illegal_op | output | 1 | High during the fetch that follows an unrecognised opcode |
| pc_load | output | 1 | Unconditional program-counter write |
| pc_load_if_zero | output | 1 | Program-counter write gated by the ALU zero result |
| addr_from_alu | output | 1 | Memory address from ALU result register (1) or PC (0) |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| ir_load | output | 1 | Instruction register write |
| rf_wr | output | 1 | Register file write |
| rf_dst_rd | output | 1 | Destination register field select: 1 = third field, 0 = second |
| wb_from_mem | output | 1 | Register write data from memory data register (1) or ALU result (0) |
| pc_src | output | 2 | PC source: 00 ALU, 01 ALU result register, 10 jump target |
| alu_ctl | output | 2 | ALU operation class: 00 add, 01 subtract, 10 function field |
| alu_a_sel | output | 1 | ALU A operand: 0 PC, 1 register A |
| alu_b_sel | output | 2 | ALU B operand: 00 register B, 01 constant 4, 10 immediate, 11 shifted immediate |

## Verification
The outputs depend only on the state, so a wrong state shows up at the ports in the same cycle as a wrong strobe or select vector. It also shows up one cycle later as a wrong successor, and as a return to fetch that comes early or late. The bench predicts the step sequence of each instruction class and compares the state and the full output vector every cycle. A wrong dispatch or a lost transition is therefore reported in the first cycle where the path diverges. An illegal opcode shows on the flag in the cycle right after decode, which lets a missing or extra flag pulse be pinned to one cycle.

// File: rtl/mc_ctrl_pkg.sv
package mc_ctrl_pkg;
  localparam int ST_W  = 4;
  localparam int OPC_W = 6;
  localparam int SEL_W = 2;

  typedef enum logic [ST_W-1:0] {
    S_FETCH   = 4'b0000,
    S_DECODE  = 4'b0001,
    S_ADDR    = 4'b0010,
    S_LD_RD   = 4'b0011,
    S_LD_WB   = 4'b0100,
    S_ST_WR   = 4'b0101,
    S_R_EXEC  = 4'b0110,
    S_R_DONE  = 4'b0111,
    S_BR_DONE = 4'b1000,
    S_J_DONE  = 4'b1001
  } step_t;

  localparam logic [OPC_W-1:0] OPC_REG   = 6'b000000;
  localparam logic [OPC_W-1:0] OPC_JUMP  = 6'b000010;
  localparam logic [OPC_W-1:0] OPC_BEQ   = 6'b000100;
  localparam logic [OPC_W-1:0] OPC_LOAD  = 6'b100011;
  localparam logic [OPC_W-1:0] OPC_STORE = 6'b101011;

  typedef struct packed {
    logic             pc_load;
    logic             pc_load_if_zero;
    logic             addr_from_alu;
    logic             mem_rd;
    logic             mem_wr;
    logic             ir_load;
    logic             rf_wr;
    logic             rf_dst_rd;
    logic             wb_from_mem;
    logic [SEL_W-1:0] pc_src;
    logic [SEL_W-1:0] alu_ctl;
    logic             alu_a_sel;
    logic [SEL_W-1:0] alu_b_sel;
  } ctrl_t;

  localparam ctrl_t CTRL_IDLE = '0;
endpackage

// File: rtl/mc_next_state.sv
module mc_next_state
  import mc_ctrl_pkg::*;
(
  input  step_t            cur,
  input  logic [OPC_W-1:0] opcode,
  output step_t            nxt,
  output logic             bad_opc
);
  always_comb begin
    nxt     = S_FETCH;
    bad_opc = 1'b0;
    unique case (cur)
      S_FETCH:  nxt = S_DECODE;
      S_DECODE: begin
        case (opcode)
          OPC_REG:              nxt = S_R_EXEC;
          OPC_JUMP:             nxt = S_J_DONE;
          OPC_BEQ:              nxt = S_BR_DONE;
          OPC_LOAD, OPC_STORE:  nxt = S_ADDR;
          default: begin
            nxt     = S_FETCH;
            bad_opc = 1'b1;
          end
        endcase
      end
      S_ADDR:   nxt = (opcode == OPC_LOAD) ? S_LD_RD : S_ST_WR;
      S_LD_RD:  nxt = S_LD_WB;
      S_R_EXEC: nxt = S_R_DONE;
      S_LD_WB, S_ST_WR, S_R_DONE, S_BR_DONE, S_J_DONE: nxt = S_FETCH;
      default:  nxt = S_FETCH;
    endcase
  end
endmodule

// File: rtl/mc_out_decode.sv
module mc_out_decode
  import mc_ctrl_pkg::*;
(
  input  step_t cur,
  output ctrl_t ctl
);
  always_comb begin
    ctl = CTRL_IDLE;
    case (cur)
      S_FETCH: begin
        ctl.pc_load   = 1'b1;
        ctl.mem_rd    = 1'b1;
        ctl.ir_load   = 1'b1;
        ctl.alu_b_sel = 2'b01;
      end
      S_DECODE: ctl.alu_b_sel = 2'b11;
      S_ADDR: begin
        ctl.alu_a_sel = 1'b1;
        ctl.alu_b_sel = 2'b10;
      end
      S_LD_RD: begin
        ctl.mem_rd        = 1'b1;
        ctl.addr_from_alu = 1'b1;
      end
      S_LD_WB: begin
        ctl.rf_wr       = 1'b1;
        ctl.wb_from_mem = 1'b1;
      end
      S_ST_WR: begin
        ctl.mem_wr        = 1'b1;
        ctl.addr_from_alu = 1'b1;
      end
      S_R_EXEC: begin
        ctl.alu_a_sel = 1'b1;
        ctl.alu_ctl   = 2'b10;
      end
      S_R_DONE: begin
        ctl.rf_wr     = 1'b1;
        ctl.rf_dst_rd = 1'b1;
      end
      S_BR_DONE: begin
        ctl.pc_load_if_zero = 1'b1;
        ctl.alu_a_sel       = 1'b1;
        ctl.alu_ctl         = 2'b01;
        ctl.pc_src          = 2'b01;
      end
      S_J_DONE: begin
        ctl.pc_load = 1'b1;
        ctl.pc_src  = 2'b10;
      end
      default: ctl = CTRL_IDLE;
    endcase
  end

  // R10
  write_strobe_excl_chk: assert final (!$isunknown(cur) -> $onehot0({ctl.mem_wr, ctl.rf_wr, ctl.ir_load, ctl.pc_load_if_zero}));
endmodule

// File: rtl/mc_state_reg.sv
module mc_state_reg
  import mc_ctrl_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  step_t nxt,
  input  logic  bad_opc,
  output step_t cur,
  output logic  illegal_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cur       <= S_FETCH;
      illegal_q <= 1'b0;
    end else begin
      cur       <= nxt;
      illegal_q <= bad_opc;
    end
  end

  // R1
  reset_state_chk: assert property (@(posedge clk) rst |=> (cur == S_FETCH && !illegal_q));
endmodule

// File: rtl/mc_seq_ctrl.sv
module mc_seq_ctrl
  import mc_ctrl_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [OPC_W-1:0] opcode,
  output logic [ST_W-1:0]  state_o,
  output logic             illegal_op,
  output logic             pc_load,
  output logic             pc_load_if_zero,
  output logic             addr_from_alu,
  output logic             mem_rd,
  output logic             mem_wr,
  output logic             ir_load,
  output logic             rf_wr,
  output logic             rf_dst_rd,
  output logic             wb_from_mem,
  output logic [SEL_W-1:0] pc_src,
  output logic [SEL_W-1:0] alu_ctl,
  output logic             alu_a_sel,
  output logic [SEL_W-1:0] alu_b_sel
);
  step_t cur_st;
  step_t nxt_st;
  logic  bad_opc;
  ctrl_t ctl;

  mc_next_state u_next (
    .cur     (cur_st),
    .opcode  (opcode),
    .nxt     (nxt_st),
    .bad_opc (bad_opc)
  );

  mc_state_reg u_reg (
    .clk       (clk),
    .rst       (rst),
    .nxt       (nxt_st),
    .bad_opc   (bad_opc),
    .cur       (cur_st),
    .illegal_q (illegal_op)
  );

  mc_out_decode u_dec (
    .cur (cur_st),
    .ctl (ctl)
  );

  assign state_o         = cur_st;
  assign pc_load         = ctl.pc_load;
  assign pc_load_if_zero = ctl.pc_load_if_zero;
  assign addr_from_alu   = ctl.addr_from_alu;
  assign mem_rd          = ctl.mem_rd;
  assign mem_wr          = ctl.mem_wr;
  assign ir_load         = ctl.ir_load;
  assign rf_wr           = ctl.rf_wr;
  assign rf_dst_rd       = ctl.rf_dst_rd;
  assign wb_from_mem     = ctl.wb_from_mem;
  assign pc_src          = ctl.pc_src;
  assign alu_ctl         = ctl.alu_ctl;
  assign alu_a_sel       = ctl.alu_a_sel;
  assign alu_b_sel       = ctl.alu_b_sel;

  // R2
  fetch_to_decode_chk: assert property (@(posedge clk) disable iff (rst)
    (state_o == 4'b0000) |=> (state_o == 4'b0001));

  // R3
  decode_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (state_o == 4'b0001) |-> !(pc_load || pc_load_if_zero || ir_load || mem_wr || rf_wr));

  // R12
  tail_return_chk: assert property (@(posedge clk) disable iff (rst)
    (state_o == 4'b0100 || state_o == 4'b0101 || state_o == 4'b0111 ||
     state_o == 4'b1000 || state_o == 4'b1001) |=> (state_o == 4'b0000));

  // R11
  illegal_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    illegal_op |-> (state_o == 4'b0000 && $past(state_o) == 4'b0001));

  // R10
  mem_rw_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));
endmodule

// File: tb/test_mc_seq_ctrl.sv
module test_mc_seq_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] opcode = 6'b0;
  logic [3:0] state_o;
  logic       illegal_op, pc_load, pc_load_if_zero, addr_from_alu, mem_rd, mem_wr;
  logic       ir_load, rf_wr, rf_dst_rd, wb_from_mem, alu_a_sel;
  logic [1:0] pc_src, alu_ctl, alu_b_sel;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  bit pend_illegal = 1'b0;

  // expected item: {illegal, state[3:0], 16-bit control vector}
  logic [20:0] exp_q[$];

  always #10 clk = ~clk;  // 50 MHz

  mc_seq_ctrl i_mc_seq_ctrl (
    .clk(clk), .rst(rst), .opcode(opcode), .state_o(state_o), .illegal_op(illegal_op),
    .pc_load(pc_load), .pc_load_if_zero(pc_load_if_zero), .addr_from_alu(addr_from_alu),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .ir_load(ir_load), .rf_wr(rf_wr),
    .rf_dst_rd(rf_dst_rd), .wb_from_mem(wb_from_mem), .pc_src(pc_src),
    .alu_ctl(alu_ctl), .alu_a_sel(alu_a_sel), .alu_b_sel(alu_b_sel)
  );

  // vector order: pc_load, pc_cond, addr, mem_rd, mem_wr, ir_load, rf_wr, rf_dst,
  //               wb_mem, pc_src[2], alu_ctl[2], a_sel, b_sel[2]
  function automatic logic [15:0] exp_ctl(input logic [3:0] s);
    case (s)
      4'b0000: exp_ctl = {1'b1,1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,2'b00,2'b00,1'b0,2'b01};
      4'b0001: exp_ctl = {9'b0,2'b00,2'b00,1'b0,2'b11};
      4'b0010: exp_ctl = {9'b0,2'b00,2'b00,1'b1,2'b10};
      4'b0011: exp_ctl = {1'b0,1'b0,1'b1,1'b1,5'b0,2'b00,2'b00,1'b0,2'b00};
      4'b0100: exp_ctl = {6'b0,1'b1,1'b0,1'b1,2'b00,2'b00,1'b0,2'b00};
      4'b0101: exp_ctl = {1'b0,1'b0,1'b1,1'b0,1'b1,4'b0,2'b00,2'b00,1'b0,2'b00};
      4'b0110: exp_ctl = {9'b0,2'b00,2'b10,1'b1,2'b00};
      4'b0111: exp_ctl = {6'b0,1'b1,1'b1,1'b0,2'b00,2'b00,1'b0,2'b00};
      4'b1000: exp_ctl = {1'b0,1'b1,7'b0,2'b01,2'b01,1'b1,2'b00};
      4'b1001: exp_ctl = {1'b1,8'b0,2'b10,2'b00,1'b0,2'b00};
      default: exp_ctl = 16'b0;
    endcase
  endfunction

  function automatic string req_of(input logic [3:0] s);
    case (s)
      4'b0000: req_of = "R2";
      4'b0001: req_of = "R3";
      4'b0010: req_of = "R4";
      4'b0011, 4'b0100: req_of = "R5";
      4'b0101: req_of = "R6";
      4'b0110, 4'b0111: req_of = "R7";
      4'b1000: req_of = "R8";
      4'b1001: req_of = "R9";
      default: req_of = "R10";
    endcase
  endfunction

  function automatic logic [15:0] act_ctl();
    act_ctl = {pc_load, pc_load_if_zero, addr_from_alu, mem_rd, mem_wr, ir_load, rf_wr,
               rf_dst_rd, wb_from_mem, pc_src, alu_ctl, alu_a_sel, alu_b_sel};
  endfunction

  task automatic push(input logic [3:0] s);
    exp_q.push_back({pend_illegal, s, exp_ctl(s)});
    pend_illegal = 1'b0;
  endtask

  // Driver: called at posedge+2 while the design sits in fetch. R12 path lengths.
  task automatic run_instr(input logic [5:0] op);
    int len;
    opcode = op;
    push(4'b0000);
    push(4'b0001);
    case (op)
      6'b000000: begin push(4'b0110); push(4'b0111); len = 4; end
      6'b000010: begin push(4'b1001); len = 3; end
      6'b000100: begin push(4'b1000); len = 3; end
      6'b100011: begin push(4'b0010); push(4'b0011); push(4'b0100); len = 5; end
      6'b101011: begin push(4'b0010); push(4'b0101); len = 4; end
      default:   begin pend_illegal = 1'b1; len = 2; end  // R11
    endcase
    repeat (len) @(posedge clk);
    #2;
  endtask

  // Monitor: compares at the falling edge
  always @(negedge clk) begin
    if (!rst && exp_q.size() > 0) begin
      logic [20:0] e;
      e = exp_q.pop_front();
      n_chk++;
      if (state_o !== e[19:16]) begin
        n_bad++;
        $display("FAIL %s/R12 state: actual %b expected %b", req_of(e[19:16]), state_o, e[19:16]);
      end
      n_chk++;
      if (act_ctl() !== e[15:0]) begin
        n_bad++;
        $display("FAIL %s/R10 controls in state %b: actual %b expected %b",
                 req_of(e[19:16]), e[19:16], act_ctl(), e[15:0]);
      end
      n_chk++;
      if (illegal_op !== e[20]) begin
        n_bad++;
        $display("FAIL R11 illegal_op: actual %b expected %b", illegal_op, e[20]);
      end
    end
  end

  task automatic reset_check(input string tag);
    @(negedge clk);
    n_chk++;
    if (state_o !== 4'b0000 || illegal_op !== 1'b0 || act_ctl() !== exp_ctl(4'b0000)) begin
      n_bad++;
      $display("FAIL R1 %s: actual state %b ill %b ctl %b expected state 0000 ill 0 ctl %b",
               tag, state_o, illegal_op, act_ctl(), exp_ctl(4'b0000));
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    reset_check("initial reset");
    @(posedge clk); #2;
    rst = 1'b0;
    run_instr(6'b000000);  // R7
    run_instr(6'b100011);  // R4 R5
    run_instr(6'b101011);  // R6
    run_instr(6'b000100);  // R8
    run_instr(6'b000010);  // R9
    run_instr(6'b111111);  // R11
    run_instr(6'b000000);
    run_instr(6'b000001);  // R11
    run_instr(6'b100010);  // R11
    run_instr(6'b100011);
    run_instr(6'b000010);
    run_instr(6'b101011);
    run_instr(6'b000100);
    // R1: reset taken mid-instruction, from the address step
    @(negedge clk);
    opcode = 6'b100011;
    repeat (2) @(posedge clk);
    #2;
    rst = 1'b1;
    @(posedge clk);
    reset_check("mid-instruction reset");
    @(posedge clk); #2;
    rst = 1'b0;
    run_instr(6'b000010);
    run_instr(6'b000000);
    @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule